// File: doc/BRIEF.md
# Single-Level Page Table Walker

The block turns a 32-bit virtual address into a physical address. It does this by reading one entry from a page table kept in main memory. A table-base register points at the table of the running process. A context switch rewrites only that register, so no other table state has to be reloaded.

For each accepted request, the block splits the address into a 20-bit page number and a 12-bit offset. It issues a single read of the entry at base plus four times the page number, and waits for the data, however many cycles that takes. It then reports the frame number joined with the offset. With the same done pulse it presents the page number, the frame number and the raw entry, so that a translation cache can be refilled.

An entry whose valid bit is clear raises a fault flag and suppresses the refill. Fault servicing and multi-level tables belong elsewhere.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `done`=0, `mem_req_valid`=0, `refill_valid`=0, and the table base is zero.
- R2: For an accepted request, the next cycle drives `mem_req_valid`=1 with `mem_req_addr` = base + (vaddr[31:12] << 2).
- R3: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged, for any number of cycles.
- R4: After the read is granted, `mem_req_valid` drops and no further read is issued. The block waits any number of cycles for `mem_rsp_valid`.
- R5: One cycle after the response is taken, `done` pulses for exactly one cycle with `paddr` = {entry[19:0], vaddr[11:0]}.
- R6: With a valid entry (bit 31 = 1), `refill_valid` is high with `done`, and `refill_vpn`=vaddr[31:12], `refill_pfn`=entry[19:0], `refill_pte`=entry.
- R7: With entry bit 31 = 0, `done` comes with `fault`=1 and `refill_valid`=0.
- R8: A base write while idle is used by the next request, including a request accepted in the same cycle as the write.
- R9: A base write during a walk does not change the walk in progress. It takes effect once the block is idle again, and the latest such write wins.
- R10: `req_ready` is low from acceptance until after `done`, and `req_valid` in that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Load the table base (context switch) |
| base_wr_data | input | 32 | New table base address |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block idle, request accepted |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Entry was invalid |
| paddr | output | 32 | Translated physical address |
| refill_valid | output | 1 | Refill fields valid |
| refill_vpn | output | 20 | Page number of the walk |
| refill_pfn | output | 20 | Frame number from the entry |
| refill_pte | output | 32 | Raw entry |

## Verification
A wrong walk state shows at the memory port within one cycle of acceptance. Such a state gives a missing or repeated read, or a read that drops before its grant. A wrong captured page number or base shows the same cycle as a wrong `mem_req_addr`. A wrong captured entry or offset appears at `paddr` and the refill fields with the next `done`. A base write that is not held back shows either as a moving entry address during a stalled read or as the wrong base on the following walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } walk_state_t;
endpackage

// File: rtl/ptw_base_ctl.sv
module ptw_base_ctl #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idle,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  output logic [PA_W-1:0] base
);
  logic            pend_q;
  logic [PA_W-1:0] pend_data_q;
  logic [PA_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q      <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else if (wr_en && !idle) begin
      pend_q      <= 1'b1;
      pend_data_q <= wr_data;
    end else if (wr_en) begin
      base_q <= wr_data;
      pend_q <= 1'b0;
    end else if (pend_q && idle) begin
      base_q <= pend_data_q;
      pend_q <= 1'b0;
    end
  end

  assign base = base_q;
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PA_W-1:0]    base,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  output logic               idle,
  output logic               mem_req_valid,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic               capture,
  output logic               done,
  output logic [VA_W-OFF_W-1:0] vpn,
  output logic [OFF_W-1:0]   off
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int ENT_SH = $clog2(PTE_W / 8);
  localparam int PAD_W  = PA_W - VPN_W - ENT_SH;

  walk_state_t st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid)     st_d = ST_READ;
      ST_READ: if (mem_req_ready) st_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) st_d = ST_DONE;
      ST_DONE:                    st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      vpn_q <= '0;
      off_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid) begin
        vpn_q <= req_vaddr[VA_W-1:OFF_W];
        off_q <= req_vaddr[OFF_W-1:0];
      end
    end
  end

  assign idle          = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_READ);
  assign mem_req_addr  = base + {{PAD_W{1'b0}}, vpn_q, {ENT_SH{1'b0}}};
  assign capture       = (st_q == ST_WAIT) && mem_rsp_valid;
  assign done          = (st_q == ST_DONE);
  assign vpn           = vpn_q;
  assign off           = off_q;
endmodule

// File: rtl/ptw_result_reg.sv
module ptw_result_reg #(
  parameter int VPN_W     = 20,
  parameter int OFF_W     = 12,
  parameter int PFN_W     = 20,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 31
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   capture,
  input  logic [PTE_W-1:0]       pte_in,
  input  logic [VPN_W-1:0]       vpn_in,
  input  logic [OFF_W-1:0]       off_in,
  output logic                   fault,
  output logic [PFN_W+OFF_W-1:0] paddr,
  output logic [VPN_W-1:0]       vpn,
  output logic [PFN_W-1:0]       pfn,
  output logic [PTE_W-1:0]       pte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fault <= 1'b0;
      paddr <= '0;
      vpn   <= '0;
      pfn   <= '0;
      pte   <= '0;
    end else if (capture) begin
      fault <= ~pte_in[VALID_BIT];
      paddr <= {pte_in[PFN_W-1:0], off_in};
      vpn   <= vpn_in;
      pfn   <= pte_in[PFN_W-1:0];
      pte   <= pte_in;
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 31,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PFN_W    = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_wr_en,
  input  logic [PA_W-1:0]  base_wr_data,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr,
  output logic             refill_valid,
  output logic [VPN_W-1:0] refill_vpn,
  output logic [PFN_W-1:0] refill_pfn,
  output logic [PTE_W-1:0] refill_pte
);
  logic             idle;
  logic             capture;
  logic [PA_W-1:0]  base;
  logic [VPN_W-1:0] walk_vpn;
  logic [OFF_W-1:0] walk_off;

  ptw_base_ctl #(.PA_W(PA_W)) base_i (
    .clk(clk), .rst(rst), .idle(idle),
    .wr_en(base_wr_en), .wr_data(base_wr_data), .base(base)
  );

  ptw_walk_fsm #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .base(base), .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .idle(idle), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .capture(capture), .done(done), .vpn(walk_vpn), .off(walk_off)
  );

  ptw_result_reg #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W),
    .PTE_W(PTE_W), .VALID_BIT(VALID_BIT)
  ) res_i (
    .clk(clk), .rst(rst), .capture(capture), .pte_in(mem_rsp_data),
    .vpn_in(walk_vpn), .off_in(walk_off), .fault(fault), .paddr(paddr),
    .vpn(refill_vpn), .pfn(refill_pfn), .pte(refill_pte)
  );

  assign req_ready    = idle;
  assign refill_valid = done & ~fault;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_req_ready,
  input logic            mem_rsp_valid,
  input logic            done
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R4
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rsp_valid));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req_valid && !req_ready));
endmodule

bind pgwalk_top pgwalk_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .done(done)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, fault, refill_valid;
  logic [31:0] paddr, refill_pte;
  logic [19:0] refill_vpn, refill_pfn;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rst(rst), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .paddr(paddr),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn),
    .refill_pfn(refill_pfn), .refill_pte(refill_pte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
  endtask

  // One walk. pre_wr loads a base together with the request (R8).
  // mid_wr writes a base during the grant stall (R9, needs gw >= 1).
  task automatic walk(input logic [31:0] va, input logic [31:0] exp_base,
                      input logic [31:0] pte, input int gw, input int rw,
                      input bit pre_wr, input bit mid_wr, input logic [31:0] wr_val);
    logic [31:0] exp_addr;
    exp_addr = exp_base + {10'd0, va[31:12], 2'b00};
    @(negedge clk);
    check("R10 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va;
    if (pre_wr) begin base_wr_en = 1'b1; base_wr_data = wr_val; end
    @(negedge clk);
    req_valid = 1'b0; base_wr_en = 1'b0;
    check("R2 read issued", {31'd0, mem_req_valid}, 32'd1);
    check("R2 entry address", mem_req_addr, exp_addr);
    check("R10 busy", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < gw; i++) begin
      if (mid_wr) begin base_wr_en = 1'b1; base_wr_data = wr_val + 32'(i); end
      req_valid = 1'b1; req_vaddr = ~va;
      @(negedge clk);
      base_wr_en = 1'b0; req_valid = 1'b0;
      check("R3 request held", {31'd0, mem_req_valid}, 32'd1);
      check("R3/R9 address stable", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check("R4 request dropped", {31'd0, mem_req_valid}, 32'd0);
    for (int i = 0; i < rw; i++) begin
      req_valid = 1'b1; req_vaddr = ~va;
      @(negedge clk);
      req_valid = 1'b0;
      check("R4 no done while waiting", {31'd0, done}, 32'd0);
      check("R4 no second read", {31'd0, mem_req_valid}, 32'd0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
    check("R5 done", {31'd0, done}, 32'd1);
    check("R7 fault", {31'd0, fault}, {31'd0, ~pte[31]});
    if (pte[31]) begin
      check("R5 paddr", paddr, {pte[19:0], va[11:0]});
      check("R6 refill_valid", {31'd0, refill_valid}, 32'd1);
      check("R6 refill_vpn", {12'd0, refill_vpn}, {12'd0, va[31:12]});
      check("R6 refill_pfn", {12'd0, refill_pfn}, {12'd0, pte[19:0]});
      check("R6 refill_pte", refill_pte, pte);
    end else begin
      check("R7 no refill", {31'd0, refill_valid}, 32'd0);
    end
    @(negedge clk);
    check("R5 done one cycle", {31'd0, done}, 32'd0);
    check("R10 ready after done", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    check("R1 refill_valid", {31'd0, refill_valid}, 32'd0);
    // R1: base is zero, so the entry address is page*4
    walk(32'h0000_5ABC, 32'h0, 32'h8001_2345, 0, 0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_idle_write;
    write_base(32'h0040_0000); // R8
    walk(32'h1234_5678, 32'h0040_0000, 32'h8000_ABCD, 0, 0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_long_waits;
    walk(32'hFFFF_FFFF, 32'h0040_0000, 32'hFFFF_FFFF, 5, 7, 1'b0, 1'b0, 32'h0); // R3 R4
    walk(32'h0000_0FFF, 32'h0040_0000, 32'h8000_0000, 1, 3, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_fault;
    walk(32'hABCD_E123, 32'h0040_0000, 32'h7FFF_FFFF, 2, 1, 1'b0, 1'b0, 32'h0); // R7
    walk(32'h0002_0010, 32'h0040_0000, 32'h0000_0000, 0, 2, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_held_write;
    // R9: writes 0x00900000 then 0x00900001 in the stall; the last one is used next
    walk(32'h0003_0004, 32'h0040_0000, 32'h8000_1111, 2, 0, 1'b0, 1'b1, 32'h0090_0000);
    walk(32'h0003_0004, 32'h0090_0001, 32'h8000_2222, 0, 1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_same_cycle;
    walk(32'h7654_3210, 32'h0100_0000, 32'h8005_4321, 1, 1, 1'b1, 1'b0, 32'h0100_0000); // R8
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_write();
    t_long_waits();
    t_fault();
    t_held_write();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule